// File: doc/BRIEF.md
# Five-Stage Pipeline Hazard and Forwarding Controller

This block is the control logic of a five-stage integer pipeline whose branches and jumps resolve in the decode stage. Each cycle it compares the source register numbers of the instructions in decode (ID) and execute (EX) against the destination registers of the instructions further down the pipe (EX, MEM, WB). From those comparisons it chooses where each operand comes from: the register file or pipeline register, the EX/MEM result, or the MEM/WB result. It makes this choice separately for the two EX-stage operands and for the two ID-stage operands. It also decides when the front of the pipe must wait and when a fetched instruction must be discarded after a taken branch.

The datapath owns the operand multiplexers, the ALU and the register file. It feeds this unit the register numbers, the write-enable and load flags of each stage, a flag that marks the ID instruction as a branch or jump that reads its operands in ID, and the taken indication from ID. The unit is purely combinational. Its clock and reset are used only by its built-in checks. A mode input turns forwarding off, and every dependency is then resolved by stalling.

The register file is assumed to be write-through: a value written in WB can be read in ID in the same cycle. For that reason WB alone never causes a stall.

Top module: `hzu_top`

## Requirements
- R1: With forwarding enabled, each EX operand select is 0 (no forward), 1 (from EX/MEM) or 2 (from MEM/WB). When both stages hold a matching destination, the EX/MEM value (the younger one) is selected.
- R2: A stage whose destination is register 0, or whose write enable is low, never produces a forward select.
- R3: A load in MEM is never forwarded from EX/MEM, because its data is not ready until WB. A matching MEM/WB destination may still be selected in that case.
- R4: The ID operand selects use the same encoding and the same priority as the EX selects. They are computed from the ID source registers and do not depend on whether the ID instruction is a branch.
- R5: A load in EX whose destination matches either ID source raises a stall.
- R6: A branch in ID stalls when a source matches a writing instruction in EX, or a writing load in MEM. An ALU producer therefore costs one stall cycle and a load producer costs two.
- R7: A stall raises the PC hold, the IF/ID hold and the ID/EX bubble together, and suppresses the IF/ID flush.
- R8: A taken branch in ID raises the IF/ID flush when there is no stall in the same cycle.
- R9: With forwarding disabled, all four selects are 0, and any match between an ID source and a writing destination in EX or MEM raises a stall.
- R10: With forwarding enabled and no condition from R5 or R6 present, no stall is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, used only by the built-in checks |
| rst_n | input | 1 | Active-low reset, disables the checks |
| fwd_en | input | 1 | 1 = forwarding enabled, 0 = stall-only mode |
| id_rs1 | input | AW | First source register of the ID instruction |
| id_rs2 | input | AW | Second source register of the ID instruction |
| id_branch | input | 1 | ID instruction is a branch or jump that reads its operands in ID |
| id_br_taken | input | 1 | Branch in ID resolved as taken |
| ex_rs1 | input | AW | First source register of the EX instruction |
| ex_rs2 | input | AW | Second source register of the EX instruction |
| ex_rd | input | AW | Destination register of the EX instruction |
| ex_we | input | 1 | EX instruction writes a register |
| ex_load | input | 1 | EX instruction is a load |
| mem_rd | input | AW | Destination register of the MEM instruction |
| mem_we | input | 1 | MEM instruction writes a register |
| mem_load | input | 1 | MEM instruction is a load |
| wb_rd | input | AW | Destination register of the WB instruction |
| wb_we | input | 1 | WB instruction writes a register |
| ex_sel_a | output | 2 | EX operand A source select |
| ex_sel_b | output | 2 | EX operand B source select |
| id_sel_a | output | 2 | ID operand A source select |
| id_sel_b | output | 2 | ID operand B source select |
| pc_hold | output | 1 | Hold the program counter |
| ifid_hold | output | 1 | Hold the IF/ID register |
| idex_bubble | output | 1 | Load a NOP into ID/EX |
| ifid_flush | output | 1 | Turn IF/ID into a NOP |

## Verification
The bench sweeps thousands of input vectors whose register fields are drawn from a small range, so that destination matches, register-0 cases and double matches occur often. Each vector is checked against a model built from the requirements. A unit that ranks MEM/WB above EX/MEM would feed stale data to back-to-back dependent instructions. One that forwards a load from MEM would pass the address instead of the data. One that forwards from register 0 would corrupt reads of the hard-wired zero. A directed sequence moves a load and then an ALU result past a dependent branch, one stage per step. This catches a design that stalls a load-dependent branch only once, or that flushes while it stalls and so loses the instruction that was waiting.

// File: rtl/hzu_pkg.sv
package hzu_pkg;
  typedef enum logic [1:0] {
    SRC_PLAIN = 2'd0,
    SRC_EXMEM = 2'd1,
    SRC_MEMWB = 2'd2
  } opsrc_e;
endpackage

// File: rtl/hzu_opsrc_pick.sv
module hzu_opsrc_pick
  import hzu_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic          fwd_en,
  input  logic [AW-1:0] rs,
  input  logic [AW-1:0] near_rd,
  input  logic          near_ok,
  input  logic [AW-1:0] far_rd,
  input  logic          far_ok,
  output opsrc_e        sel
);
  logic near_hit;
  logic far_hit;

  always_comb begin
    near_hit = fwd_en && near_ok && (near_rd != '0) && (near_rd == rs);
    far_hit  = fwd_en && far_ok  && (far_rd  != '0) && (far_rd  == rs);
    if (near_hit)     sel = SRC_EXMEM;
    else if (far_hit) sel = SRC_MEMWB;
    else              sel = SRC_PLAIN;
  end
endmodule

// File: rtl/hzu_stall_detect.sv
module hzu_stall_detect #(
  parameter int AW = 5
) (
  input  logic          fwd_en,
  input  logic [AW-1:0] id_rs1,
  input  logic [AW-1:0] id_rs2,
  input  logic          id_branch,
  input  logic [AW-1:0] ex_rd,
  input  logic          ex_we,
  input  logic          ex_load,
  input  logic [AW-1:0] mem_rd,
  input  logic          mem_we,
  input  logic          mem_load,
  output logic          stall
);
  logic ex_hit;
  logic mem_hit;

  always_comb begin
    ex_hit  = ex_we  && (ex_rd  != '0) && ((ex_rd  == id_rs1) || (ex_rd  == id_rs2));
    mem_hit = mem_we && (mem_rd != '0) && ((mem_rd == id_rs1) || (mem_rd == id_rs2));
    if (fwd_en)
      stall = (ex_hit && (ex_load || id_branch)) || (mem_hit && mem_load && id_branch);
    else
      stall = ex_hit || mem_hit;
  end
endmodule

// File: rtl/hzu_top.sv
module hzu_top
  import hzu_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fwd_en,
  input  logic [AW-1:0] id_rs1,
  input  logic [AW-1:0] id_rs2,
  input  logic          id_branch,
  input  logic          id_br_taken,
  input  logic [AW-1:0] ex_rs1,
  input  logic [AW-1:0] ex_rs2,
  input  logic [AW-1:0] ex_rd,
  input  logic          ex_we,
  input  logic          ex_load,
  input  logic [AW-1:0] mem_rd,
  input  logic          mem_we,
  input  logic          mem_load,
  input  logic [AW-1:0] wb_rd,
  input  logic          wb_we,
  output logic [1:0]    ex_sel_a,
  output logic [1:0]    ex_sel_b,
  output logic [1:0]    id_sel_a,
  output logic [1:0]    id_sel_b,
  output logic          pc_hold,
  output logic          ifid_hold,
  output logic          idex_bubble,
  output logic          ifid_flush
);
  localparam int NPICK = 4;

  logic [AW-1:0] pick_rs [NPICK];
  opsrc_e        pick_sel [NPICK];
  logic          mem_fwd_ok;
  logic          stall;

  assign mem_fwd_ok = mem_we && !mem_load;
  assign pick_rs[0] = ex_rs1;
  assign pick_rs[1] = ex_rs2;
  assign pick_rs[2] = id_rs1;
  assign pick_rs[3] = id_rs2;

  for (genvar g = 0; g < NPICK; g++) begin : g_pick
    hzu_opsrc_pick #(.AW(AW)) u_pick (
      .fwd_en  (fwd_en),
      .rs      (pick_rs[g]),
      .near_rd (mem_rd),
      .near_ok (mem_fwd_ok),
      .far_rd  (wb_rd),
      .far_ok  (wb_we),
      .sel     (pick_sel[g])
    );
  end

  hzu_stall_detect #(.AW(AW)) u_stall (
    .fwd_en    (fwd_en),
    .id_rs1    (id_rs1),
    .id_rs2    (id_rs2),
    .id_branch (id_branch),
    .ex_rd     (ex_rd),
    .ex_we     (ex_we),
    .ex_load   (ex_load),
    .mem_rd    (mem_rd),
    .mem_we    (mem_we),
    .mem_load  (mem_load),
    .stall     (stall)
  );

  always_comb begin
    ex_sel_a    = pick_sel[0];
    ex_sel_b    = pick_sel[1];
    id_sel_a    = pick_sel[2];
    id_sel_b    = pick_sel[3];
    pc_hold     = stall;
    ifid_hold   = stall;
    idex_bubble = stall;
    ifid_flush  = id_br_taken && !stall;
  end

  // R1
  younger_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_sel_a == 2'd2) |-> !(mem_we && !mem_load && mem_rd != '0 && mem_rd == ex_rs1));

  // R2
  zero_dst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd == '0 && wb_rd == '0) |->
      (ex_sel_a == 2'd0 && ex_sel_b == 2'd0 && id_sel_a == 2'd0 && id_sel_b == 2'd0));

  // R3
  load_mem_nofwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_load |-> (ex_sel_a != 2'd1 && ex_sel_b != 2'd1 && id_sel_a != 2'd1 && id_sel_b != 2'd1));

  // R5
  load_use_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_load && ex_we && ex_rd != '0 && (ex_rd == id_rs1 || ex_rd == id_rs2)) |-> pc_hold);

  // R7
  hold_no_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idex_bubble |-> (!ifid_flush && pc_hold && ifid_hold));

  // R9
  fwd_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fwd_en |-> (ex_sel_a == 2'd0 && ex_sel_b == 2'd0 && id_sel_a == 2'd0 && id_sel_b == 2'd0));
endmodule

// File: tb/hzu_top_tb.sv
module hzu_top_tb;
  localparam int AW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fwd_en, id_branch, id_br_taken, ex_we, ex_load, mem_we, mem_load, wb_we;
  logic [AW-1:0] id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, wb_rd;
  logic [1:0] ex_sel_a, ex_sel_b, id_sel_a, id_sel_b;
  logic pc_hold, ifid_hold, idex_bubble, ifid_flush;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  hzu_top #(.AW(AW)) u_dut (.*);

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int exp_sel(input logic [AW-1:0] rs);
    if (!fwd_en) return 0;
    if (mem_we && !mem_load && mem_rd != 0 && mem_rd == rs) return 1;
    if (wb_we && wb_rd != 0 && wb_rd == rs) return 2;
    return 0;
  endfunction

  function automatic int exp_stall();
    bit eh, mh;
    eh = ex_we && ex_rd != 0 && (ex_rd == id_rs1 || ex_rd == id_rs2);
    mh = mem_we && mem_rd != 0 && (mem_rd == id_rs1 || mem_rd == id_rs2);
    if (!fwd_en) return int'(eh || mh);
    return int'((eh && (ex_load || id_branch)) || (mh && mem_load && id_branch));
  endfunction

  task automatic clear();
    {fwd_en, id_branch, id_br_taken, ex_we, ex_load, mem_we, mem_load, wb_we} = '0;
    {id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, wb_rd} = '0;
    fwd_en = 1'b1;
  endtask

  task automatic settle();
    @(negedge clk);
    #2;
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    clear();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    settle();
    // R10 reset state
    chk("R10 idle stall", int'(pc_hold), 0);
    chk("R8 idle flush", int'(ifid_flush), 0);

    // R1 both stages match: EX/MEM wins
    clear(); ex_rs1 = 5'd3; mem_rd = 5'd3; mem_we = 1; wb_rd = 5'd3; wb_we = 1;
    settle(); chk("R1 younger wins", int'(ex_sel_a), 1);
    // R2 x0 destination
    clear(); ex_rs2 = 0; mem_rd = 0; mem_we = 1; wb_rd = 0; wb_we = 1;
    settle(); chk("R2 x0 no fwd", int'(ex_sel_b), 0);
    // R2 we low
    clear(); ex_rs1 = 5'd4; mem_rd = 5'd4; wb_rd = 5'd4;
    settle(); chk("R2 we low", int'(ex_sel_a), 0);
    // R3 load in MEM falls through to MEM/WB
    clear(); ex_rs1 = 5'd6; mem_rd = 5'd6; mem_we = 1; mem_load = 1; wb_rd = 5'd6; wb_we = 1;
    settle(); chk("R3 load mem", int'(ex_sel_a), 2);
    // R4 ID forwarding without branch flag
    clear(); id_rs2 = 5'd9; mem_rd = 5'd9; mem_we = 1;
    settle(); chk("R4 id fwd", int'(id_sel_b), 1);
    // R9 stall-only mode
    clear(); fwd_en = 0; id_rs1 = 5'd2; mem_rd = 5'd2; mem_we = 1; ex_rs1 = 5'd2;
    settle(); chk("R9 stall", int'(pc_hold), 1); chk("R9 no fwd", int'(ex_sel_a), 0);

    // R6 load then dependent branch: two stalls, then forward from MEM/WB
    clear(); id_branch = 1; id_br_taken = 1; id_rs1 = 5'd7; ex_rd = 5'd7; ex_we = 1; ex_load = 1;
    settle(); chk("R6 load b1 stall", int'(pc_hold), 1); chk("R7 no flush", int'(ifid_flush), 0);
    ex_we = 0; ex_load = 0; ex_rd = 0; mem_rd = 5'd7; mem_we = 1; mem_load = 1;
    settle(); chk("R6 load b2 stall", int'(ifid_hold), 1);
    mem_we = 0; mem_load = 0; mem_rd = 0; wb_rd = 5'd7; wb_we = 1;
    settle(); chk("R6 load b3 go", int'(pc_hold), 0); chk("R6 id sel", int'(id_sel_a), 2);
    chk("R8 flush", int'(ifid_flush), 1);
    // R6 ALU then dependent branch: one stall
    clear(); id_branch = 1; id_rs2 = 5'd8; ex_rd = 5'd8; ex_we = 1;
    settle(); chk("R6 alu b1 stall", int'(idex_bubble), 1);
    ex_we = 0; ex_rd = 0; mem_rd = 5'd8; mem_we = 1;
    settle(); chk("R6 alu b2 go", int'(pc_hold), 0); chk("R6 alu sel", int'(id_sel_b), 1);

    // sweep
    for (int n = 0; n < 6000; n++) begin
      @(negedge clk);
      fwd_en = ($urandom % 4) != 0;
      {id_branch, id_br_taken, ex_we, ex_load, mem_we, mem_load, wb_we} = 7'($urandom);
      id_rs1 = AW'($urandom % 4); id_rs2 = AW'($urandom % 4);
      ex_rs1 = AW'($urandom % 4); ex_rs2 = AW'($urandom % 4);
      ex_rd = AW'($urandom % 4); mem_rd = AW'($urandom % 4); wb_rd = AW'($urandom % 4);
      #2;
      chk("R1 ex a", int'(ex_sel_a), exp_sel(ex_rs1));
      chk("R1 ex b", int'(ex_sel_b), exp_sel(ex_rs2));
      chk("R4 id a", int'(id_sel_a), exp_sel(id_rs1));
      chk("R4 id b", int'(id_sel_b), exp_sel(id_rs2));
      chk("R5 stall", int'(pc_hold), exp_stall());
      chk("R7 group", int'({ifid_hold, idex_bubble}), exp_stall() * 3);
      chk("R8 flush", int'(ifid_flush), int'(id_br_taken && exp_stall() == 0));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule